// File: doc/BRIEF.md
# Idle-Time Power Mode Controller

This block chooses the operating mode of an optical motion sensor from the time that has passed since motion was last reported. Four modes exist: Run and three rest levels, each slower than the one before it. The block counts time-base ticks while no motion arrives and steps down one level each time the idle count crosses a threshold. A motion pulse brings it straight back to Run. In every mode it issues a one-cycle frame trigger at that mode's period. It raises an LED enable for a short window that starts with each trigger, so the LED is never held on continuously.

A two-bit forced-mode field, taken from a configuration register, can pin the controller at any rest level. The mode output always shows the live mode, so it can be returned on register readback. A power-down control bit puts the block into a latched low-power state. In that state there are no frames, no LED pulses and no mode changes. Only the hard reset or the soft-reset strobe ends it. All periods and thresholds are parameters counted in ticks. The block has no data stream, so every pin is a plain control or status signal.

Top module: `pmc_power_mode`

## Requirements
- R1: After reset, mode_o is 00, low_pwr_o is 0, and frame_o and led_o are 0.
- R2: mode_o uses the codes 00 Run, 01 Rest1, 10 Rest2 and 11 Rest3. The mode stays Run while fewer than IDLE_T1 ticks have arrived since the last motion.
- R3: With force_mode_i at 00 and no motion, mode_o becomes 01 once IDLE_T1 ticks have been counted since the last motion, 10 at IDLE_T2 ticks and 11 at IDLE_T3 ticks. It then stays 11 however many further ticks arrive.
- R4: With force_mode_i at 00, a motion_i pulse returns mode_o to 00 and clears the idle count.
- R5: A nonzero force_mode_i sets mode_o to that value. The mode then does not downshift on ticks and ignores motion_i.
- R6: When force_mode_i returns to 00, mode_o goes to 00 and the idle count restarts from zero.
- R7: frame_o pulses for one clock on the tick that completes each period of the current mode: PER_RUN ticks in Run, PER_R1 in Rest1, PER_R2 in Rest2 and PER_R3 in Rest3. The period count restarts when the mode changes.
- R8: led_o rises in the same cycle as frame_o and stays high for exactly LED_CYC clocks. It is never high at any other time.
- R9: A cycle with pwr_down_i high sets low_pwr_o from the next clock on. The setting is latched. While it is set there are no frame or LED pulses, and the mode and idle count are frozen, including against motion.
- R10: low_pwr_o clears only on rst_n low or a soft_rst_i strobe. The strobe restores the full reset state of R1, and the idle count restarts from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low hard reset |
| tick_i | input | 1 | One-cycle time-base tick |
| motion_i | input | 1 | One-cycle pulse: motion was reported |
| force_mode_i | input | 2 | Forced rest level; 00 means automatic |
| pwr_down_i | input | 1 | Power-down control bit |
| soft_rst_i | input | 1 | One-cycle soft-reset strobe |
| mode_o | output | 2 | Live mode code for readback |
| frame_o | output | 1 | One-cycle frame trigger |
| led_o | output | 1 | LED enable window |
| low_pwr_o | output | 1 | Low-power state flag |

## Verification
The hardest states to reach from the ports are the top rest level and its saturation. Reaching them takes a long run of ticks with no motion. The bench therefore shrinks every threshold and period to a few ticks, so that a short table of tick bursts walks through all three downshifts and past the last one. Frame periods cannot be seen from a single sample. To measure them, the bench pins the mode with the forced field, counts frame_o and led_o cycles over a known number of ticks, and compares the totals with the values the period and the LED window length give.

// File: rtl/pmc_pkg.sv
package pmc_pkg;
  typedef enum logic [1:0] {
    M_RUN   = 2'b00,
    M_REST1 = 2'b01,
    M_REST2 = 2'b10,
    M_REST3 = 2'b11
  } pmode_e;
endpackage

// File: rtl/pmc_mode_seq.sv
module pmc_mode_seq
  import pmc_pkg::*;
#(
  parameter int IDLE_T1 = 1000,
  parameter int IDLE_T2 = 7000,
  parameter int IDLE_T3 = 410000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       srst,
  input  logic       hold,
  input  logic       tick,
  input  logic       motion,
  input  logic [1:0] force_mode,
  output pmode_e     mode
);
  localparam int IW = $clog2(IDLE_T3 + 1);
  localparam logic [IW-1:0] LIM1 = IW'(IDLE_T1);
  localparam logic [IW-1:0] LIM2 = IW'(IDLE_T2);
  localparam logic [IW-1:0] LIM3 = IW'(IDLE_T3);

  logic [IW-1:0] idle_q, idle_nx;
  pmode_e        mode_q;

  function automatic pmode_e level_of(input logic [IW-1:0] idle);
    if (idle >= LIM3)      return M_REST3;
    else if (idle >= LIM2) return M_REST2;
    else if (idle >= LIM1) return M_REST1;
    else                   return M_RUN;
  endfunction

  always_comb begin
    idle_nx = idle_q;
    if (tick && idle_q != LIM3) idle_nx = idle_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idle_q <= '0;
      mode_q <= M_RUN;
    end else if (srst) begin
      idle_q <= '0;
      mode_q <= M_RUN;
    end else if (hold) begin
      idle_q <= idle_q;
      mode_q <= mode_q;
    end else if (force_mode != 2'b00) begin
      idle_q <= '0;
      mode_q <= pmode_e'(force_mode);
    end else if (motion) begin
      idle_q <= '0;
      mode_q <= M_RUN;
    end else begin
      idle_q <= idle_nx;
      mode_q <= level_of(idle_nx);
    end
  end

  assign mode = mode_q;

  // R4: motion in automatic operation returns to Run
  a_r4_motion_run: assert property (@(posedge clk) disable iff (!rst_n)
    (motion && force_mode == 2'b00 && !hold && !srst) |=> mode_q == M_RUN);

  // R5: a nonzero forced field sets the mode
  a_r5_forced: assert property (@(posedge clk) disable iff (!rst_n)
    (force_mode != 2'b00 && !hold && !srst) |=> mode_q == pmode_e'($past(force_mode)));

  // R3: automatic downshift moves exactly one level at a time
  a_r3_one_step: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(mode_q) && mode_q != M_RUN && $past(force_mode) == 2'b00)
      |-> (2'(mode_q) == 2'($past(mode_q)) + 2'd1));
endmodule

// File: rtl/pmc_frame_gen.sv
module pmc_frame_gen
  import pmc_pkg::*;
#(
  parameter int PER_RUN = 1,
  parameter int PER_R1  = 14,
  parameter int PER_R2  = 68,
  parameter int PER_R3  = 340,
  parameter int LED_CYC = 4
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   srst,
  input  logic   pd,
  input  logic   tick,
  input  pmode_e mode,
  output logic   frame_o,
  output logic   led_o
);
  localparam int PMAX = (PER_R3 > PER_R2) ? ((PER_R3 > PER_R1) ? PER_R3 : PER_R1)
                                          : ((PER_R2 > PER_R1) ? PER_R2 : PER_R1);
  localparam int PTOP = (PMAX > PER_RUN) ? PMAX : PER_RUN;
  localparam int PW   = $clog2(PTOP + 1);
  localparam int LW   = $clog2(LED_CYC + 1);

  function automatic int period_of(input int idx);
    case (idx)
      0:       return PER_RUN;
      1:       return PER_R1;
      2:       return PER_R2;
      default: return PER_R3;
    endcase
  endfunction

  logic [PW-1:0] last_tab [4];
  for (genvar g = 0; g < 4; g++) begin : g_per
    assign last_tab[g] = PW'(period_of(g) - 1);
  end

  logic [PW-1:0] cnt_q;
  logic [LW-1:0] led_q;
  pmode_e        prev_q;
  logic          frame_q;
  logic          fire;

  assign fire = tick && !pd && (mode == prev_q) && (cnt_q == last_tab[mode]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      led_q   <= '0;
      prev_q  <= M_RUN;
      frame_q <= 1'b0;
    end else if (srst) begin
      cnt_q   <= '0;
      led_q   <= '0;
      prev_q  <= M_RUN;
      frame_q <= 1'b0;
    end else begin
      prev_q  <= mode;
      frame_q <= fire;
      if (pd) begin
        led_q <= '0;
      end else if (fire) begin
        led_q <= LW'(LED_CYC);
      end else if (led_q != '0) begin
        led_q <= led_q - 1'b1;
      end
      if (mode != prev_q) begin
        cnt_q <= '0;
      end else if (tick && !pd) begin
        cnt_q <= fire ? '0 : cnt_q + 1'b1;
      end
    end
  end

  assign frame_o = frame_q;
  assign led_o   = (led_q != '0);

  // R8: the LED window only opens together with a frame trigger
  a_r8_led_with_frame: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(led_o) |-> frame_o);

  // R7: a frame trigger always follows a tick
  a_r7_frame_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    frame_o |-> $past(tick));

  // R9: no activity once power down has been held for a cycle
  a_r9_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (pd && $past(pd)) |-> (!frame_o && !led_o));
endmodule

// File: rtl/pmc_power_mode.sv
module pmc_power_mode
  import pmc_pkg::*;
#(
  parameter int IDLE_T1 = 1000,
  parameter int IDLE_T2 = 7000,
  parameter int IDLE_T3 = 410000,
  parameter int PER_RUN = 1,
  parameter int PER_R1  = 14,
  parameter int PER_R2  = 68,
  parameter int PER_R3  = 340,
  parameter int LED_CYC = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_i,
  input  logic       motion_i,
  input  logic [1:0] force_mode_i,
  input  logic       pwr_down_i,
  input  logic       soft_rst_i,
  output logic [1:0] mode_o,
  output logic       frame_o,
  output logic       led_o,
  output logic       low_pwr_o
);
  logic   pd_q;
  pmode_e mode;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          pd_q <= 1'b0;
    else if (soft_rst_i) pd_q <= 1'b0;
    else if (pwr_down_i) pd_q <= 1'b1;
  end

  pmc_mode_seq #(
    .IDLE_T1(IDLE_T1), .IDLE_T2(IDLE_T2), .IDLE_T3(IDLE_T3)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .srst(soft_rst_i), .hold(pd_q),
    .tick(tick_i), .motion(motion_i), .force_mode(force_mode_i), .mode(mode)
  );

  pmc_frame_gen #(
    .PER_RUN(PER_RUN), .PER_R1(PER_R1), .PER_R2(PER_R2), .PER_R3(PER_R3),
    .LED_CYC(LED_CYC)
  ) u_frm (
    .clk(clk), .rst_n(rst_n), .srst(soft_rst_i), .pd(pd_q),
    .tick(tick_i), .mode(mode), .frame_o(frame_o), .led_o(led_o)
  );

  assign mode_o    = mode;
  assign low_pwr_o = pd_q;

  // R9: low-power state is latched once entered
  a_r9_latched: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(low_pwr_o) && !$past(soft_rst_i)) |-> low_pwr_o);

  // R10: soft reset leaves low power and returns to Run
  a_r10_soft_exit: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst_i |=> (!low_pwr_o && mode_o == 2'b00));
endmodule

// File: tb/sim_pmc_power_mode.sv
module sim_pmc_power_mode;
  localparam int T1 = 4, T2 = 8, T3 = 12;
  localparam int PR = 2, P1 = 3, P2 = 4, P3 = 5, LC = 2;

  logic clk = 1'b0, rst_n = 1'b0, tick_i = 1'b0, motion_i = 1'b0;
  logic [1:0] force_mode_i = 2'b00;
  logic pwr_down_i = 1'b0, soft_rst_i = 1'b0;
  logic [1:0] mode_o;
  logic frame_o, led_o, low_pwr_o;

  int checks = 0, fails = 0;
  int fcnt = 0, lcnt = 0;
  logic mon_en = 1'b0;

  always #2 clk = ~clk;

  pmc_power_mode #(
    .IDLE_T1(T1), .IDLE_T2(T2), .IDLE_T3(T3),
    .PER_RUN(PR), .PER_R1(P1), .PER_R2(P2), .PER_R3(P3), .LED_CYC(LC)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .motion_i(motion_i),
    .force_mode_i(force_mode_i), .pwr_down_i(pwr_down_i), .soft_rst_i(soft_rst_i),
    .mode_o(mode_o), .frame_o(frame_o), .led_o(led_o), .low_pwr_o(low_pwr_o)
  );

  always @(negedge clk) if (mon_en) begin
    if (frame_o) fcnt++;
    if (led_o) lcnt++;
  end

  // op {3b}, arg {6b}, expected mode {2b}, expected low power {1b}, requirement {4b}
  // ops: 0 ticks, 1 motion, 2 force, 3 power down, 4 soft reset
  localparam logic [15:0] VEC [21] = '{
    {3'd0, 6'd3,  2'd0, 1'b0, 4'd2},   // R2 below first threshold
    {3'd0, 6'd1,  2'd1, 1'b0, 4'd3},   // R3 reaches Rest1
    {3'd1, 6'd0,  2'd0, 1'b0, 4'd4},   // R4 motion wakes
    {3'd0, 6'd8,  2'd2, 1'b0, 4'd3},   // R3 reaches Rest2
    {3'd0, 6'd3,  2'd2, 1'b0, 4'd3},   // R3 one short of Rest3
    {3'd0, 6'd1,  2'd3, 1'b0, 4'd3},   // R3 reaches Rest3
    {3'd0, 6'd20, 2'd3, 1'b0, 4'd3},   // R3 saturates
    {3'd1, 6'd0,  2'd0, 1'b0, 4'd4},   // R4 motion from Rest3
    {3'd2, 6'd2,  2'd2, 1'b0, 4'd5},   // R5 force Rest2
    {3'd0, 6'd20, 2'd2, 1'b0, 4'd5},   // R5 no downshift while forced
    {3'd1, 6'd0,  2'd2, 1'b0, 4'd5},   // R5 motion ignored while forced
    {3'd2, 6'd0,  2'd0, 1'b0, 4'd6},   // R6 release
    {3'd2, 6'd3,  2'd3, 1'b0, 4'd5},   // R5 force Rest3
    {3'd2, 6'd1,  2'd1, 1'b0, 4'd5},   // R5 force Rest1
    {3'd2, 6'd0,  2'd0, 1'b0, 4'd6},   // R6 release again
    {3'd0, 6'd3,  2'd0, 1'b0, 4'd6},   // R6 timer restarted
    {3'd3, 6'd0,  2'd0, 1'b1, 4'd9},   // R9 power down latched
    {3'd0, 6'd20, 2'd0, 1'b1, 4'd9},   // R9 frozen
    {3'd1, 6'd0,  2'd0, 1'b1, 4'd10},  // R10 motion does not wake
    {3'd4, 6'd0,  2'd0, 1'b0, 4'd10},  // R10 soft reset exits
    {3'd0, 6'd4,  2'd1, 1'b0, 4'd10}   // R10 timer counted from zero
  };

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) tick_i = 1'b1;
      @(negedge clk) tick_i = 1'b0;
      repeat (2) @(negedge clk);
    end
  endtask

  task automatic pulse(input int which);
    @(negedge clk);
    if (which == 1) motion_i = 1'b1;
    if (which == 3) pwr_down_i = 1'b1;
    if (which == 4) soft_rst_i = 1'b1;
    @(negedge clk);
    motion_i = 1'b0; pwr_down_i = 1'b0; soft_rst_i = 1'b0;
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  task automatic measure(input int n, output int f, output int l);
    fcnt = 0; lcnt = 0; mon_en = 1'b1;
    do_ticks(n);
    repeat (LC + 3) @(negedge clk);
    mon_en = 1'b0;
    f = fcnt; l = lcnt;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", checks - fails + 1, checks + 1);
    $finish;
  end

  initial begin
    int f, l;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 mode", mode_o, 0);
    chk("R1 low_pwr", low_pwr_o, 0);
    chk("R1 frame", frame_o, 0);
    chk("R1 led", led_o, 0);
    rst_n = 1'b1;
    settle();

    foreach (VEC[i]) begin
      logic [2:0] op;
      logic [5:0] arg;
      op = VEC[i][15:13]; arg = VEC[i][12:7];
      case (op)
        3'd0: do_ticks(int'(arg));
        3'd2: begin @(negedge clk) force_mode_i = arg[1:0]; end
        default: pulse(int'(op));
      endcase
      settle();
      chk($sformatf("R%0d vec%0d mode", VEC[i][3:0], i), mode_o, int'(VEC[i][6:5]));
      chk($sformatf("R%0d vec%0d low_pwr", VEC[i][3:0], i), low_pwr_o, int'(VEC[i][4]));
    end

    // R7 / R8 frame periods and LED window, measured under forced modes
    @(negedge clk) force_mode_i = 2'b01; settle();
    measure(12, f, l);
    chk("R7 Rest1 frames", f, 12 / P1);
    chk("R8 Rest1 led cycles", l, (12 / P1) * LC);
    @(negedge clk) force_mode_i = 2'b11; settle();
    measure(15, f, l);
    chk("R7 Rest3 frames", f, 15 / P3);
    chk("R8 Rest3 led cycles", l, (15 / P3) * LC);
    @(negedge clk) force_mode_i = 2'b10; settle();
    measure(8, f, l);
    chk("R7 Rest2 frames", f, 8 / P2);
    @(negedge clk) force_mode_i = 2'b00; settle();
    fcnt = 0; lcnt = 0; mon_en = 1'b1;
    for (int k = 0; k < 3; k++) begin
      do_ticks(PR);
      pulse(1);
    end
    repeat (LC + 3) @(negedge clk);
    mon_en = 1'b0;
    chk("R7 Run frames", fcnt, 3);
    chk("R8 Run led cycles", lcnt, 3 * LC);
    chk("R4 still Run", mode_o, 0);

    // R9 no frames or LED while powered down
    pulse(3); settle();
    measure(20, f, l);
    chk("R9 frames in power down", f, 0);
    chk("R9 led in power down", l, 0);
    chk("R9 low_pwr held", low_pwr_o, 1);

    // R10 hard reset also leaves low power
    @(negedge clk) rst_n = 1'b0;
    @(negedge clk) rst_n = 1'b1;
    settle();
    chk("R10 hard reset low_pwr", low_pwr_o, 0);
    chk("R10 hard reset mode", mode_o, 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule